// File: doc/BRIEF.md
# BCD Time-of-Day Register Bank

This block keeps calendar time in a bank of eight byte-wide registers. A one-second tick from outside advances seconds, minutes, hours, weekday, date, month and a two-digit year. Carries ripple through all fields. Month lengths are honoured, and leap years are derived from a base-year parameter. Software reads and writes every field as packed BCD through a byte request channel.

Every time field checks its range on a write. An out-of-range value leaves the field as it was. The seconds register carries a stop flag that freezes the count. The control register always reads back a fixed pattern in its upper bits. Inside the block the time is held in binary, so an accepted write is normalised. For example, a seconds byte of 0x4A reads back as 0x50.

Requests use a valid/ready channel. Read data comes back on a separate valid/ready response channel with a single slot. The block stops accepting new requests while an unconsumed response is waiting, so back-pressure on the response side stalls the request side.

Top module: `rtc_tod_regfile`

## Requirements
- R1: Register addresses are 0 control, 1 seconds, 2 minutes, 3 hours, 4 day, 5 date, 6 month and 7 year. After reset they read 0x90, 0x00, 0x00, 0x00, 0x01, 0x01, 0x01 and 0x00.
- R2: A request is taken when req_valid and req_ready are both high. The rule is req_ready = !rsp_valid || rsp_ready. Read data appears with rsp_valid in the cycle after acceptance. It is held unchanged until rsp_ready is high.
- R3: A control write stores (value AND 0x5F) OR 0x90.
- R4: Bit 7 of any seconds write sets the stop flag, whether or not the seconds value is accepted. While the flag is set, ticks leave the time unchanged. A seconds read returns {stop, BCD seconds}.
- R5: For seconds and minutes the value is tens (bits 6:4) times 10 plus ones (bits 3:0), and it is accepted only if it is 59 or less. For hours the value is tens (bits 5:4) times 10 plus ones, and it is accepted only if it is 23 or less. A rejected value leaves the field unchanged.
- R6: A date write is accepted when tens (bits 5:4) times 10 plus ones is nonzero. A month write is accepted when tens (bit 4) times 10 plus ones lies from 1 to 12.
- R7: A day write stores bits 2:0 as the weekday and bit 6 as the century flag. A day read returns {0, century, 000, weekday}.
- R8: A year write is accepted when tens (bits 7:4) times 10 plus ones is 99 or less.
- R9: A tick while running increments seconds. Seconds roll from 59 to 0 into minutes, minutes from 59 to 0 into hours, and hours from 23 to 0 into the day.
- R10: At midnight a date at or above the month length becomes 1 and carries into the month. The length is 30 for months 4, 6, 9 and 11, and 31 for the other months except February. February has 29 days when (BASE_YEAR + year) mod 4 is 0 and 28 otherwise. At the same midnight a weekday of 7 or 0 becomes 1, and any other weekday increments.
- R11: Month 12 rolls over to 1 and increments the year. Year 99 rolls over to 00.
- R12: When a tick and a time-field write land in the same cycle, the tick is applied first and the written field then overrides its result. The stop flag that gates this tick is the value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_tick | input | 1 | One-cycle pulse per second |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request ready |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 3 | Register address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_ready | input | 1 | Read data consumed |
| rsp_rdata | output | 8 | Read data |

## Verification
A write or a tick updates the registers at the clock edge that accepts it, so its effect can be seen through any read issued after that edge. Read data is registered at the accepting edge and is due one cycle later. The bench drives inputs on the falling edge and samples rsp_rdata on the falling edge that follows acceptance. Each write and tick is applied to a bench model at that same point. A back-pressure case holds rsp_ready low for several cycles. It confirms that req_ready stays low and the data stays stable, and that the waiting read is served on the edge where the old response drains.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int REG_AW = 3;
  localparam int BYTE_W = 8;

  typedef enum logic [REG_AW-1:0] {
    RA_CTRL  = 3'd0,
    RA_SEC   = 3'd1,
    RA_MIN   = 3'd2,
    RA_HOUR  = 3'd3,
    RA_DAY   = 3'd4,
    RA_DATE  = 3'd5,
    RA_MONTH = 3'd6,
    RA_YEAR  = 3'd7
  } reg_addr_e;

  localparam logic [BYTE_W-1:0] CTRL_KEEP  = 8'h5F;
  localparam logic [BYTE_W-1:0] CTRL_FORCE = 8'h90;

  typedef struct packed {
    logic [5:0] sec;
    logic [5:0] min;
    logic [4:0] hour;
    logic [2:0] wday;
    logic [5:0] date;
    logic [3:0] month;
    logic [6:0] year;
  } tod_t;

  typedef struct packed {
    logic              ld_ctrl;
    logic              ld_stop;
    logic              ld_sec;
    logic              ld_min;
    logic              ld_hour;
    logic              ld_day;
    logic              ld_date;
    logic              ld_month;
    logic              ld_year;
    logic [BYTE_W-1:0] ctrl;
    logic              stop;
    logic [5:0]        sec;
    logic [5:0]        min;
    logic [4:0]        hour;
    logic [2:0]        wday;
    logic              cent;
    logic [5:0]        date;
    logic [3:0]        month;
    logic [6:0]        year;
  } wr_cmd_t;

  function automatic logic [7:0] bcd_to_bin(input logic [3:0] tens, input logic [3:0] ones);
    return 8'(tens) * 8'd10 + 8'(ones);
  endfunction

  function automatic logic [7:0] bin_to_bcd(input logic [6:0] v);
    logic [6:0] t;
    logic [6:0] o;
    t = v / 7'd10;
    o = v % 7'd10;
    return {t[3:0], o[3:0]};
  endfunction

  function automatic logic [4:0] month_days(input logic [3:0] m, input logic leap);
    case (m)
      4'd2:                      return leap ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11:   return 5'd30;
      default:                   return 5'd31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_wr_decode.sv
module rtc_wr_decode
  import rtc_pkg::*;
(
  input  logic              wr_en,
  input  logic [REG_AW-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  output wr_cmd_t           cmd
);
  logic [7:0] v_ms, v_hour, v_date, v_month, v_year;

  always_comb begin
    v_ms    = bcd_to_bin({1'b0, wdata[6:4]}, wdata[3:0]);
    v_hour  = bcd_to_bin({2'b0, wdata[5:4]}, wdata[3:0]);
    v_date  = v_hour;
    v_month = bcd_to_bin({3'b0, wdata[4]}, wdata[3:0]);
    v_year  = bcd_to_bin(wdata[7:4], wdata[3:0]);

    cmd          = '0;
    cmd.ctrl     = (wdata & CTRL_KEEP) | CTRL_FORCE;
    cmd.stop     = wdata[7];
    cmd.sec      = v_ms[5:0];
    cmd.min      = v_ms[5:0];
    cmd.hour     = v_hour[4:0];
    cmd.wday     = wdata[2:0];
    cmd.cent     = wdata[6];
    cmd.date     = v_date[5:0];
    cmd.month    = v_month[3:0];
    cmd.year     = v_year[6:0];

    if (wr_en) begin
      case (reg_addr_e'(addr))
        RA_CTRL:  cmd.ld_ctrl  = 1'b1;
        RA_SEC: begin
          cmd.ld_stop = 1'b1;
          cmd.ld_sec  = (v_ms <= 8'd59);
        end
        RA_MIN:   cmd.ld_min   = (v_ms <= 8'd59);
        RA_HOUR:  cmd.ld_hour  = (v_hour <= 8'd23);
        RA_DAY:   cmd.ld_day   = 1'b1;
        RA_DATE:  cmd.ld_date  = (v_date != 8'd0);
        RA_MONTH: cmd.ld_month = (v_month >= 8'd1) && (v_month <= 8'd12);
        RA_YEAR:  cmd.ld_year  = (v_year <= 8'd99);
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/rtc_time_core.sv
module rtc_time_core
  import rtc_pkg::*;
#(
  parameter int BASE_YEAR = 2000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sec_tick,
  input  wr_cmd_t           cmd,
  output tod_t              tod_q,
  output logic              stop_q,
  output logic              cent_q,
  output logic [BYTE_W-1:0] ctrl_q
);
  localparam int          BASE_MOD4 = ((BASE_YEAR % 4) + 4) % 4;
  localparam logic [1:0]  BASE_LO   = 2'(BASE_MOD4);

  tod_t       nx;
  logic       leap;
  logic [4:0] dim;

  always_comb begin
    leap = ((tod_q.year[1:0] + BASE_LO) == 2'd0);
    dim  = month_days(tod_q.month, leap);
    nx   = tod_q;
    if (sec_tick && !stop_q) begin
      if (tod_q.sec >= 6'd59) begin
        nx.sec = '0;
        if (tod_q.min >= 6'd59) begin
          nx.min = '0;
          if (tod_q.hour >= 5'd23) begin
            nx.hour = '0;
            nx.wday = (tod_q.wday >= 3'd7 || tod_q.wday == 3'd0) ? 3'd1 : tod_q.wday + 3'd1;
            if (tod_q.date >= {1'b0, dim}) begin
              nx.date = 6'd1;
              if (tod_q.month >= 4'd12) begin
                nx.month = 4'd1;
                nx.year  = (tod_q.year >= 7'd99) ? 7'd0 : tod_q.year + 7'd1;
              end else begin
                nx.month = tod_q.month + 4'd1;
              end
            end else begin
              nx.date = tod_q.date + 6'd1;
            end
          end else begin
            nx.hour = tod_q.hour + 5'd1;
          end
        end else begin
          nx.min = tod_q.min + 6'd1;
        end
      end else begin
        nx.sec = tod_q.sec + 6'd1;
      end
    end
    if (cmd.ld_sec)   nx.sec   = cmd.sec;
    if (cmd.ld_min)   nx.min   = cmd.min;
    if (cmd.ld_hour)  nx.hour  = cmd.hour;
    if (cmd.ld_day)   nx.wday  = cmd.wday;
    if (cmd.ld_date)  nx.date  = cmd.date;
    if (cmd.ld_month) nx.month = cmd.month;
    if (cmd.ld_year)  nx.year  = cmd.year;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tod_q  <= '{sec: '0, min: '0, hour: '0, wday: 3'd1, date: 6'd1, month: 4'd1, year: '0};
      stop_q <= 1'b0;
      cent_q <= 1'b0;
      ctrl_q <= CTRL_FORCE;
    end else begin
      tod_q <= nx;
      if (cmd.ld_stop) stop_q <= cmd.stop;
      if (cmd.ld_day)  cent_q <= cmd.cent;
      if (cmd.ld_ctrl) ctrl_q <= cmd.ctrl;
    end
  end
endmodule

// File: rtl/rtc_rd_port.sv
module rtc_rd_port
  import rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [REG_AW-1:0] req_addr,
  output logic              req_ready,
  output logic              wr_en,
  input  logic              rsp_ready,
  output logic              rsp_valid,
  output logic [BYTE_W-1:0] rsp_rdata,
  input  tod_t              tod_q,
  input  logic              stop_q,
  input  logic              cent_q,
  input  logic [BYTE_W-1:0] ctrl_q
);
  logic              accept;
  logic [BYTE_W-1:0] rd_mux;
  logic [7:0]        bcd_sec;

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign wr_en     = accept && req_write;

  always_comb begin
    bcd_sec = bin_to_bcd({1'b0, tod_q.sec});
    case (reg_addr_e'(req_addr))
      RA_CTRL:  rd_mux = ctrl_q;
      RA_SEC:   rd_mux = {stop_q, bcd_sec[6:0]};
      RA_MIN:   rd_mux = bin_to_bcd({1'b0, tod_q.min});
      RA_HOUR:  rd_mux = bin_to_bcd({2'b0, tod_q.hour});
      RA_DAY:   rd_mux = {1'b0, cent_q, 3'b000, tod_q.wday};
      RA_DATE:  rd_mux = bin_to_bcd({1'b0, tod_q.date});
      RA_MONTH: rd_mux = bin_to_bcd({3'b0, tod_q.month});
      default:  rd_mux = bin_to_bcd(tod_q.year);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (accept && !req_write) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= rd_mux;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/rtc_tod_regfile.sv
module rtc_tod_regfile
  import rtc_pkg::*;
#(
  parameter int BASE_YEAR = 2000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sec_tick,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [REG_AW-1:0] req_addr,
  input  logic [BYTE_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [BYTE_W-1:0] rsp_rdata
);
  logic              wr_en;
  wr_cmd_t           cmd;
  tod_t              tod_q;
  logic              stop_q;
  logic              cent_q;
  logic [BYTE_W-1:0] ctrl_q;

  rtc_wr_decode u_dec (
    .wr_en (wr_en),
    .addr  (req_addr),
    .wdata (req_wdata),
    .cmd   (cmd)
  );

  rtc_time_core #(.BASE_YEAR(BASE_YEAR)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .sec_tick (sec_tick),
    .cmd      (cmd),
    .tod_q    (tod_q),
    .stop_q   (stop_q),
    .cent_q   (cent_q),
    .ctrl_q   (ctrl_q)
  );

  rtc_rd_port u_port (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_ready (req_ready),
    .wr_en     (wr_en),
    .rsp_ready (rsp_ready),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .tod_q     (tod_q),
    .stop_q    (stop_q),
    .cent_q    (cent_q),
    .ctrl_q    (ctrl_q)
  );
endmodule

// File: rtl/rtc_tod_checks.sv
module rtc_tod_checks (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic       req_write,
  input logic [2:0] req_addr,
  input logic       rsp_valid,
  input logic       rsp_ready,
  input logic [7:0] rsp_rdata,
  input logic       wr_en,
  input logic       stop_q,
  input logic [5:0] tod_sec,
  input logic [4:0] tod_hour
);
  a_r2_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));

  a_r2_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);

  a_r3_ctrl_pattern: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_write && req_addr == 3'd0)
      |=> (rsp_valid && ((rsp_rdata & 8'hB0) == 8'h90)));

  a_r4_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_q && !(wr_en && req_addr == 3'd1)) |=> $stable(tod_sec));

  a_r5_sec_range: assert property (@(posedge clk) disable iff (!rst_n)
    tod_sec <= 6'd59);

  a_r5_hour_range: assert property (@(posedge clk) disable iff (!rst_n)
    tod_hour <= 5'd23);
endmodule

bind rtc_tod_regfile rtc_tod_checks u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_write (req_write),
  .req_addr  (req_addr),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_rdata (rsp_rdata),
  .wr_en     (wr_en),
  .stop_q    (stop_q),
  .tod_sec   (tod_q.sec),
  .tod_hour  (tod_q.hour)
);

// File: tb/rtc_tod_regfile_test.sv
module rtc_tod_regfile_test;
  localparam int BENCH_BASE = 1999;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sec_tick = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic       req_write = 1'b0;
  logic [2:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic       rsp_valid;
  logic       rsp_ready = 1'b1;
  logic [7:0] rsp_rdata;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  rtc_tod_regfile #(.BASE_YEAR(BENCH_BASE)) uut (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata)
  );

  // bench model
  int m_sec, m_min, m_hr, m_wd, m_date, m_mon, m_yr;
  bit m_stop, m_cent;
  logic [7:0] m_ctrl;

  task automatic model_reset();
    m_sec = 0; m_min = 0; m_hr = 0; m_wd = 1; m_date = 1; m_mon = 1; m_yr = 0;
    m_stop = 0; m_cent = 0; m_ctrl = 8'h90;
  endtask

  function automatic int days_of(int mon, int yr);
    if (mon == 2) return (((BENCH_BASE + yr) % 4) == 0) ? 29 : 28;
    if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
    return 31;
  endfunction

  function automatic logic [7:0] to_bcd(int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  task automatic model_tick();
    if (m_stop) return;
    m_sec++;
    if (m_sec < 60) return;
    m_sec = 0; m_min++;
    if (m_min < 60) return;
    m_min = 0; m_hr++;
    if (m_hr < 24) return;
    m_hr = 0;
    m_wd = (m_wd == 7 || m_wd == 0) ? 1 : m_wd + 1;
    if (m_date >= days_of(m_mon, m_yr)) begin
      m_date = 1;
      if (m_mon == 12) begin
        m_mon = 1;
        m_yr = (m_yr == 99) ? 0 : m_yr + 1;
      end else m_mon++;
    end else m_date++;
  endtask

  task automatic model_write(input logic [2:0] a, input logic [7:0] d);
    int v;
    case (a)
      3'd0: m_ctrl = (d & 8'h5F) | 8'h90;
      3'd1: begin v = int'(d[6:4]) * 10 + int'(d[3:0]); if (v <= 59) m_sec = v; m_stop = d[7]; end
      3'd2: begin v = int'(d[6:4]) * 10 + int'(d[3:0]); if (v <= 59) m_min = v; end
      3'd3: begin v = int'(d[5:4]) * 10 + int'(d[3:0]); if (v <= 23) m_hr = v; end
      3'd4: begin m_wd = int'(d[2:0]); m_cent = d[6]; end
      3'd5: begin v = int'(d[5:4]) * 10 + int'(d[3:0]); if (v != 0) m_date = v; end
      3'd6: begin v = int'(d[4]) * 10 + int'(d[3:0]); if (v >= 1 && v <= 12) m_mon = v; end
      default: begin v = int'(d[7:4]) * 10 + int'(d[3:0]); if (v <= 99) m_yr = v; end
    endcase
  endtask

  function automatic logic [7:0] exp_read(input logic [2:0] a);
    case (a)
      3'd0: return m_ctrl;
      3'd1: return {m_stop, to_bcd(m_sec)[6:0]};
      3'd2: return to_bcd(m_min);
      3'd3: return to_bcd(m_hr);
      3'd4: return {1'b0, m_cent, 3'b000, 3'(m_wd)};
      3'd5: return to_bcd(m_date);
      3'd6: return to_bcd(m_mon);
      default: return to_bcd(m_yr);
    endcase
  endfunction

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic do_write(input logic [2:0] a, input logic [7:0] d, input bit with_tick);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d; sec_tick = with_tick;
    @(negedge clk);
    req_valid = 0; req_write = 0; sec_tick = 0;
    if (with_tick) model_tick();
    model_write(a, d);
  endtask

  task automatic do_tick();
    @(negedge clk);
    sec_tick = 1;
    @(negedge clk);
    sec_tick = 0;
    model_tick();
  endtask

  task automatic do_read(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = a;
    @(negedge clk);
    req_valid = 0;
    d = rsp_valid ? rsp_rdata : 8'hXX;
  endtask

  task automatic check_reg(input logic [2:0] a, input string tag);
    logic [7:0] d;
    do_read(a, d);
    check(tag, d, exp_read(a));
  endtask

  task automatic set_time(input logic [7:0] yr, input logic [7:0] mo, input logic [7:0] dt,
                          input logic [7:0] hr, input logic [7:0] mi, input logic [7:0] se);
    do_write(3'd7, yr, 0);
    do_write(3'd6, mo, 0);
    do_write(3'd5, dt, 0);
    do_write(3'd3, hr, 0);
    do_write(3'd2, mi, 0);
    do_write(3'd1, se, 0);
  endtask

  initial begin : watchdog
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        fails++; checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

  initial begin : stim
    logic [7:0] d;
    logic [7:0] held;
    int r;
    r = $urandom(32'd7321);
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    for (int a = 0; a < 8; a++) check_reg(3'(a), "R1 reset");

    // R3 control forced pattern
    do_write(3'd0, 8'hFF, 0); check_reg(3'd0, "R3 ctrl ff");
    do_write(3'd0, 8'h00, 0); check_reg(3'd0, "R3 ctrl 00");
    do_write(3'd0, 8'h6A, 0); check_reg(3'd0, "R3 ctrl 6a");

    // R5 range rejection and normalisation
    do_write(3'd1, 8'h60, 0); check_reg(3'd1, "R5 sec 60 rejected");
    do_write(3'd1, 8'h4A, 0); check_reg(3'd1, "R5 sec 4a normalised");
    do_write(3'd2, 8'h5A, 0); check_reg(3'd2, "R5 min 5a rejected");
    do_write(3'd3, 8'h24, 0); check_reg(3'd3, "R5 hour 24 rejected");
    do_write(3'd3, 8'h23, 0); check_reg(3'd3, "R5 hour 23 kept");
    // R6 date / month
    do_write(3'd5, 8'h00, 0); check_reg(3'd5, "R6 date 00 rejected");
    do_write(3'd5, 8'hC0, 0); check_reg(3'd5, "R6 date c0 rejected");
    do_write(3'd6, 8'h13, 0); check_reg(3'd6, "R6 month 13 rejected");
    do_write(3'd6, 8'h00, 0); check_reg(3'd6, "R6 month 00 rejected");
    do_write(3'd6, 8'h12, 0); check_reg(3'd6, "R6 month 12 kept");
    // R7 day register
    do_write(3'd4, 8'hFD, 0); check_reg(3'd4, "R7 day fd");
    // R8 year
    do_write(3'd7, 8'hA0, 0); check_reg(3'd7, "R8 year a0 rejected");
    do_write(3'd7, 8'h99, 0); check_reg(3'd7, "R8 year 99 kept");

    // R4 stop bit
    do_write(3'd1, 8'h95, 0); check_reg(3'd1, "R4 stop set");
    repeat (3) do_tick();
    check_reg(3'd1, "R4 frozen");
    do_write(3'd1, 8'hE0, 0); check_reg(3'd1, "R4 stop with bad value");
    do_write(3'd1, 8'h15, 0); do_tick(); check_reg(3'd1, "R4 resumed");

    // R9 cascade
    set_time(8'h10, 8'h05, 8'h10, 8'h09, 8'h59, 8'h59);
    do_tick(); check_reg(3'd1, "R9 sec wrap"); check_reg(3'd2, "R9 min wrap"); check_reg(3'd3, "R9 hour inc");
    // R10 30-day month and weekday 7->1
    do_write(3'd4, 8'h07, 0);
    set_time(8'h10, 8'h04, 8'h30, 8'h23, 8'h59, 8'h59);
    do_tick(); check_reg(3'd5, "R10 apr30 date"); check_reg(3'd6, "R10 apr30 month"); check_reg(3'd4, "R10 weekday wrap");
    // R10 leap: base 1999 + 25 = 2024
    set_time(8'h25, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59);
    do_tick(); check_reg(3'd5, "R10 leap feb29"); check_reg(3'd6, "R10 leap month");
    set_time(8'h24, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59);
    do_tick(); check_reg(3'd5, "R10 nonleap mar1"); check_reg(3'd6, "R10 nonleap month");
    // R11 year wrap
    set_time(8'h99, 8'h12, 8'h31, 8'h23, 8'h59, 8'h59);
    do_tick(); check_reg(3'd6, "R11 month wrap"); check_reg(3'd7, "R11 year wrap"); check_reg(3'd5, "R11 date");
    // R12 write with tick in same cycle
    set_time(8'h30, 8'h06, 8'h15, 8'h10, 8'h59, 8'h59);
    do_write(3'd3, 8'h05, 1);
    check_reg(3'd3, "R12 hour override"); check_reg(3'd2, "R12 min carried"); check_reg(3'd1, "R12 sec carried");

    // R2 back-pressure
    @(negedge clk);
    rsp_ready = 0; req_valid = 1; req_write = 0; req_addr = 3'd1;
    @(negedge clk);
    held = rsp_rdata;
    check("R2 rsp valid", {7'd0, rsp_valid}, 8'h01);
    check("R2 first data", held, exp_read(3'd1));
    req_addr = 3'd2;
    repeat (3) begin
      @(negedge clk);
      check("R2 ready low", {7'd0, req_ready}, 8'h00);
      check("R2 data held", rsp_rdata, held);
    end
    rsp_ready = 1;
    @(negedge clk);
    req_valid = 0;
    check("R2 second rsp valid", {7'd0, rsp_valid}, 8'h01);
    check("R2 second data", rsp_rdata, exp_read(3'd2));
    @(negedge clk);

    // random mix (R9 R10 R11 R12 R4-R8)
    for (int i = 0; i < 3000; i++) begin
      int op;
      op = $urandom_range(0, 9);
      if (op < 5) do_tick();
      else if (op < 7) do_write(3'($urandom_range(0, 7)), 8'($urandom_range(0, 255)), 0);
      else if (op < 8) do_write(3'($urandom_range(0, 7)), 8'($urandom_range(0, 255)), 1);
      else check_reg(3'($urandom_range(0, 7)), "R9 random read");
      if (op == 9 && m_stop) do_write(3'd1, to_bcd($urandom_range(0, 59)), 0);
    end
    for (int a = 0; a < 8; a++) check_reg(3'(a), "R10 random final");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule